// File: doc/BRIEF.md
# Minute/Second Interrupt Pulse Generator

This block turns the once-per-second and once-per-minute tick events of a real-time clock into an active-low interrupt line. Two enable bits choose which events are of interest: second events, minute events, or both. Every enabled event sets a sticky status flag. Software clears the flag with a one-cycle clear strobe.

A mode bit picks between two behaviours of the interrupt line. In pulsed mode the line goes low for a fixed number of periods of a 64 Hz timing enable and then returns high, while the flag stays set. In level mode the line stays low for as long as the flag is set and at least one enable is on. In either mode, clearing the flag releases the line at the next clock, so a serviced interrupt does not have to wait for its pulse to finish. The pulse length is the parameter `PULSE_TICKS`, counted in 64 Hz enables. It defaults to one period, which is 1/64 s.

Top module: `msi_int_gen`

## Requirements
- R1: After synchronous reset, `irq_n` is 1 and `flag` is 0.
- R2: A second event is `sec_tick` or `min_tick` high while `sec_irq_en` is 1. A minute event is `min_tick` high while `min_irq_en` is 1. Ticks that meet neither condition leave `flag` and `irq_n` unchanged.
- R3: `flag` reads 1 from the clock after an enabled event, in either mode. It stays 1 until a cycle in which `flag_clr` is high and no event occurs. When an event and `flag_clr` fall in the same cycle, `flag` stays 1.
- R4: With `pulse_sel` = 1, `irq_n` reads 0 from the clock after an event. It returns to 1 on the clock that samples the `PULSE_TICKS`-th `tick64` after the event, and `flag` remains 1 after that.
- R5: In either mode, a `flag_clr` with no event in the same cycle drives `irq_n` to 1 at the next clock.
- R6: With `pulse_sel` = 0, `irq_n` is 0 exactly while `flag` is 1 and at least one of `sec_irq_en` and `min_irq_en` is 1. Clearing both enables releases the line.
- R7: An event that arrives during an active pulse restarts the count, so the line stays low for `PULSE_TICKS` further `tick64` enables, counted from that event.
- R8: When `min_tick` and `sec_tick` are high together and both enables are set, only one pulse is produced, with the normal length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick64 | input | 1 | One-cycle enable at 64 Hz |
| sec_tick | input | 1 | One-cycle pulse at each new second |
| min_tick | input | 1 | One-cycle pulse at each minute rollover |
| sec_irq_en | input | 1 | Enable for second events |
| min_irq_en | input | 1 | Enable for minute events |
| pulse_sel | input | 1 | 1 = pulsed interrupt, 0 = level interrupt |
| flag_clr | input | 1 | One-cycle strobe that writes zero to the flag |
| flag | output | 1 | Sticky event status flag |
| irq_n | output | 1 | Active-low interrupt output |

## Verification
The bench builds the block with `PULSE_TICKS` = 3. This makes the start, middle and end of a pulse separately observable, and it leaves room for a retrigger partway through a pulse. The bench sweeps all eight combinations of the two enables and the mode bit against the three non-empty tick patterns. For each case it computes from the enables whether an event occurs, then follows the line through every 64 Hz enable of the pulse. Directed cases cover a clear in the middle of a pulse, a clear that lands in the same cycle as an event, a retrigger, and the release of level mode by dropping both enables.

// File: rtl/msi_pkg.sv
package msi_pkg;

    typedef enum logic {
        MODE_LEVEL = 1'b0,
        MODE_PULSE = 1'b1
    } msi_mode_e;

    typedef struct packed {
        logic      min_en;
        logic      sec_en;
        msi_mode_e mode;
    } msi_cfg_t;

    function automatic int cnt_bits(input int ticks);
        return (ticks < 2) ? 1 : $clog2(ticks + 1);
    endfunction

endpackage

// File: rtl/msi_event_sel.sv
module msi_event_sel (
    input  logic clk,
    input  logic rst,
    input  logic sec_en,
    input  logic min_en,
    input  logic sec_tick,
    input  logic min_tick,
    output logic event_o
);
    logic sec_hit;
    logic min_hit;

    always_comb begin
        sec_hit = sec_en & (sec_tick | min_tick);
        min_hit = min_en & min_tick;
        event_o = sec_hit | min_hit;
    end

    // R2
    no_enable_no_event_chk: assert property (@(posedge clk) disable iff (rst)
        (!sec_en && !min_en) |-> !event_o);

    // R2
    quiet_ticks_chk: assert property (@(posedge clk) disable iff (rst)
        (!sec_tick && !min_tick) |-> !event_o);
endmodule

// File: rtl/msi_flag.sv
module msi_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk) begin
        if (rst)
            flag_o <= 1'b0;
        else if (set_i)
            flag_o <= 1'b1;
        else if (clr_i)
            flag_o <= 1'b0;
    end

    // R3
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_o && !clr_i) |=> flag_o);

    // R3
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        set_i |=> flag_o);
endmodule

// File: rtl/msi_pulse_timer.sv
module msi_pulse_timer #(
    parameter int PULSE_TICKS = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    input  logic stop_i,
    input  logic tick_i,
    output logic active_o
);
    localparam int CNT_W = msi_pkg::cnt_bits(PULSE_TICKS);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(PULSE_TICKS);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= LOAD_VAL;
        else if (stop_i)
            cnt_q <= '0;
        else if (tick_i && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign active_o = (cnt_q != '0);

    // R7
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (cnt_q == LOAD_VAL));

    // R4
    idle_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (!active_o && !load_i) |=> !active_o);
endmodule

// File: rtl/msi_int_gen.sv
module msi_int_gen #(
    parameter int PULSE_TICKS = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic tick64,
    input  logic sec_tick,
    input  logic min_tick,
    input  logic sec_irq_en,
    input  logic min_irq_en,
    input  logic pulse_sel,
    input  logic flag_clr,
    output logic flag,
    output logic irq_n
);
    import msi_pkg::*;

    msi_cfg_t cfg;
    logic     ev;
    logic     pulse_on;
    logic     irq_req;

    always_comb begin
        cfg.min_en = min_irq_en;
        cfg.sec_en = sec_irq_en;
        cfg.mode   = msi_mode_e'(pulse_sel);
    end

    msi_event_sel u_sel (
        .clk      (clk),
        .rst      (rst),
        .sec_en   (cfg.sec_en),
        .min_en   (cfg.min_en),
        .sec_tick (sec_tick),
        .min_tick (min_tick),
        .event_o  (ev)
    );

    msi_flag u_flag (
        .clk    (clk),
        .rst    (rst),
        .set_i  (ev),
        .clr_i  (flag_clr),
        .flag_o (flag)
    );

    msi_pulse_timer #(.PULSE_TICKS(PULSE_TICKS)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load_i   (ev),
        .stop_i   (flag_clr),
        .tick_i   (tick64),
        .active_o (pulse_on)
    );

    always_comb begin
        if (cfg.mode == MODE_PULSE)
            irq_req = flag & pulse_on;
        else
            irq_req = flag & (cfg.min_en | cfg.sec_en);
        irq_n = ~irq_req;
    end

    // R1
    idle_line_chk: assert property (@(posedge clk) disable iff (rst)
        !flag |-> irq_n);

    // R5
    clear_release_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !ev) |=> irq_n);

    // R4
    pulse_end_chk: assert property (@(posedge clk) disable iff (rst)
        (pulse_sel && !pulse_on) |-> irq_n);

    // R6
    level_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!pulse_sel && flag && (sec_irq_en || min_irq_en)) |-> !irq_n);
endmodule

// File: tb/msi_int_gen_test.sv
module msi_int_gen_test;
    localparam int PT = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick64 = 1'b0, sec_tick = 1'b0, min_tick = 1'b0;
    logic sec_irq_en = 1'b0, min_irq_en = 1'b0, pulse_sel = 1'b0, flag_clr = 1'b0;
    logic flag, irq_n;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    msi_int_gen #(.PULSE_TICKS(PT)) uut (
        .clk(clk), .rst(rst), .tick64(tick64), .sec_tick(sec_tick),
        .min_tick(min_tick), .sec_irq_en(sec_irq_en), .min_irq_en(min_irq_en),
        .pulse_sel(pulse_sel), .flag_clr(flag_clr), .flag(flag), .irq_n(irq_n)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Drive one cycle of strobes, return after the capturing edge.
    task automatic cyc(input logic s, input logic m, input logic t, input logic c);
        @(negedge clk);
        sec_tick = s; min_tick = m; tick64 = t; flag_clr = c;
        @(negedge clk);
        sec_tick = 1'b0; min_tick = 1'b0; tick64 = 1'b0; flag_clr = 1'b0;
    endtask

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 irq_n", irq_n, 1'b1);
        check("R1 flag", flag, 1'b0);

        // Sweep: cfg {min_en, sec_en, mode} x tick pattern {s, m}
        for (int c = 0; c < 8; c++) begin
            for (int p = 1; p < 4; p++) begin
                logic me, se, pm, s, m, ev;
                me = c[2]; se = c[1]; pm = c[0];
                s = p[0]; m = p[1];
                ev = (se && (s || m)) || (me && m);
                min_irq_en = me; sec_irq_en = se; pulse_sel = pm;
                cyc(s, m, 1'b0, 1'b0);
                // R2 / R3 event decode and flag set
                check("R2 flag after tick", flag, ev);
                check("R3 irq_n at event", irq_n, !ev);
                for (int k = 1; k <= PT; k++) begin
                    cyc(1'b0, 1'b0, 1'b1, 1'b0);
                    if (pm)
                        // R4 pulse length, R8 single pulse for combined ticks
                        check("R4 R8 pulse window", irq_n, !(ev && k < PT));
                    else
                        check("R6 level hold", irq_n, !ev);
                    check("R3 flag sticky", flag, ev);
                end
                cyc(1'b0, 1'b0, 1'b0, 1'b1);
                check("R5 clear releases", irq_n, 1'b1);
                check("R3 clear", flag, 1'b0);
            end
        end

        // R5 clear in mid-pulse
        min_irq_en = 1'b0; sec_irq_en = 1'b1; pulse_sel = 1'b1;
        cyc(1'b1, 1'b0, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 1'b1, 1'b0);
        check("R5 mid-pulse low", irq_n, 1'b0);
        cyc(1'b0, 1'b0, 1'b0, 1'b1);
        check("R5 shortened pulse", irq_n, 1'b1);
        check("R5 flag cleared", flag, 1'b0);
        cyc(1'b0, 1'b0, 1'b1, 1'b0);
        check("R5 stays released", irq_n, 1'b1);

        // R3 event and clear in same cycle
        cyc(1'b1, 1'b0, 1'b0, 1'b1);
        check("R3 event beats clear", flag, 1'b1);
        check("R3 line low", irq_n, 1'b0);
        for (int k = 0; k < PT; k++) cyc(1'b0, 1'b0, 1'b1, 1'b0);
        cyc(1'b0, 1'b0, 1'b0, 1'b1);

        // R7 retrigger
        cyc(1'b1, 1'b0, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 1'b1, 1'b0);
        cyc(1'b1, 1'b0, 1'b0, 1'b0);
        for (int k = 1; k < PT; k++) begin
            cyc(1'b0, 1'b0, 1'b1, 1'b0);
            check("R7 restarted pulse low", irq_n, 1'b0);
        end
        cyc(1'b0, 1'b0, 1'b1, 1'b0);
        check("R7 restarted pulse ends", irq_n, 1'b1);
        check("R7 flag still set", flag, 1'b1);
        cyc(1'b0, 1'b0, 1'b0, 1'b1);

        // R2 disabled tick ignored while flag clear
        sec_irq_en = 1'b0; min_irq_en = 1'b1;
        cyc(1'b1, 1'b0, 1'b0, 1'b0);
        check("R2 second tick ignored", flag, 1'b0);
        check("R2 line idle", irq_n, 1'b1);

        // R6 level release by dropping both enables
        pulse_sel = 1'b0;
        cyc(1'b0, 1'b1, 1'b0, 1'b0);
        check("R6 level asserted", irq_n, 1'b0);
        @(negedge clk);
        min_irq_en = 1'b0;
        @(negedge clk);
        check("R6 released by enables", irq_n, 1'b1);
        check("R6 flag kept", flag, 1'b1);
        sec_irq_en = 1'b1;
        @(negedge clk);
        check("R6 re-enable reasserts", irq_n, 1'b0);
        cyc(1'b0, 1'b0, 1'b0, 1'b1);
        check("R5 level clear", irq_n, 1'b1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule